// File: doc/BRIEF.md
# Operand-Routing Bit-Slice Logic Unit

This block is a bitwise logic unit assembled from identical one-bit slices. Every slice sees three data bits. It routes two of them, chosen by a two-bit operand code, onto an internal pair of operands. A second two-bit code then selects one of four bitwise logic functions of that pair. The operand code rotates which pair of the three inputs is used. Its fourth value forces both operands to zero, so that the chosen function produces a known constant.

The word-wide unit places `WIDTH` slices side by side. All slices share the same two codes, and no signal passes between slices. This keeps every output bit a function of the same bit position of the three inputs only. The combined word is captured in a result register. That register has a synchronous clear and a load enable, and the registered word is the only output.

Top module: `bsa_alu`

## Requirements
- R1: With operand code 2'b00, the first operand is `din_a` and the second is `din_b`.
- R2: With operand code 2'b01, the first operand is `din_b` and the second is `din_c`.
- R3: With operand code 2'b10, the first operand is `din_c` and the second is `din_a`.
- R4: With operand code 2'b11, both operands are zero whatever the data inputs are. The loaded result is then all zeros for AND, OR and XOR, and all ones for XNOR.
- R5: Function code 2'b00 produces the bitwise AND of the two operands, and 2'b01 produces their bitwise OR.
- R6: Function code 2'b10 produces the bitwise XNOR of the two operands, and 2'b11 produces their bitwise XOR.
- R7: Each result bit depends only on the bits at the same position of the three data inputs. Neighbouring positions have no effect on it.
- R8: When `load_en` is high at a rising clock edge and `rst` is low, `result` takes the computed word right after that edge.
- R9: When `load_en` is low at a rising clock edge and `rst` is low, `result` keeps its previous value, whatever the codes and data inputs are.
- R10: When `rst` is high at a rising clock edge, `result` becomes zero after that edge, even if `load_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous clear of the result register, active high |
| load_en | input | 1 | Captures the computed word into the result register |
| op_sel | input | 2 | Operand routing code |
| fn_sel | input | 2 | Logic function code |
| din_a | input | WIDTH | First data word |
| din_b | input | WIDTH | Second data word |
| din_c | input | WIDTH | Third data word |
| result | output | WIDTH | Registered result word |

## Verification
The clocked properties assume that `rst` is high at the first rising edge. They also assume that the codes and `load_en` hold steady, known values around each edge, so a sampled code always matches the word captured at that edge. The bench asserts reset before the first edge. It changes every input only on falling edges and drives only known values. It steps through all sixteen code pairs with data words that differ bit by bit, and it also covers load-disabled cycles and reset with load enabled.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

   typedef enum logic [1:0] {
      ROUTE_AB   = 2'b00,
      ROUTE_BC   = 2'b01,
      ROUTE_CA   = 2'b10,
      ROUTE_ZERO = 2'b11
   } route_e;

   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_XNOR = 2'b10,
      FN_XOR  = 2'b11
   } logic_fn_e;

   typedef struct packed {
      logic p;
      logic q;
   } operand_pair_t;

endpackage

// File: rtl/bsa_operand_mux.sv
module bsa_operand_mux
   import bsa_pkg::*;
(
   input  route_e        route,
   input  logic          bit_a,
   input  logic          bit_b,
   input  logic          bit_c,
   output operand_pair_t pair
);

   // rotating 3-to-2 selection; the last code forces both operands low (R4)
   always_comb begin
      unique case (route)
         ROUTE_AB: pair = '{p: bit_a, q: bit_b};   // R1
         ROUTE_BC: pair = '{p: bit_b, q: bit_c};   // R2
         ROUTE_CA: pair = '{p: bit_c, q: bit_a};   // R3
         default:  pair = '{p: 1'b0,  q: 1'b0};    // R4
      endcase
   end

endmodule

// File: rtl/bsa_logic_unit.sv
module bsa_logic_unit
   import bsa_pkg::*;
(
   input  logic_fn_e     fn,
   input  operand_pair_t pair,
   output logic          y
);

   always_comb begin
      unique case (fn)
         FN_AND:  y = pair.p & pair.q;       // R5
         FN_OR:   y = pair.p | pair.q;       // R5
         FN_XNOR: y = ~(pair.p ^ pair.q);    // R6
         default: y = pair.p ^ pair.q;       // R6
      endcase
   end

endmodule

// File: rtl/bsa_slice.sv
module bsa_slice
   import bsa_pkg::*;
(
   input  route_e    route,
   input  logic_fn_e fn,
   input  logic      bit_a,
   input  logic      bit_b,
   input  logic      bit_c,
   output logic      y
);

   operand_pair_t pair;

   bsa_operand_mux u_mux (
      .route (route),
      .bit_a (bit_a),
      .bit_b (bit_b),
      .bit_c (bit_c),
      .pair  (pair)
   );

   bsa_logic_unit u_fn (
      .fn   (fn),
      .pair (pair),
      .y    (y)
   );

endmodule

// File: rtl/bsa_result_reg.sv
module bsa_result_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)          q <= '0;   // R10
      else if (load_en) q <= d;    // R8
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(q));                                        // R9

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (q == '0));                                              // R10

endmodule

// File: rtl/bsa_alu.sv
module bsa_alu
   import bsa_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [1:0]       op_sel,
   input  logic [1:0]       fn_sel,
   input  logic [WIDTH-1:0] din_a,
   input  logic [WIDTH-1:0] din_b,
   input  logic [WIDTH-1:0] din_c,
   output logic [WIDTH-1:0] result
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   if (WIDTH < 1) begin : g_bad_width
      $error("bsa_alu: WIDTH must be at least 1");
   end

   route_e           route;
   logic_fn_e        fn;
   logic [WIDTH-1:0] word;

   assign route = route_e'(op_sel);
   assign fn    = logic_fn_e'(fn_sel);

   // independent slices, shared codes, no inter-slice wiring (R7)
   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      bsa_slice u_slice (
         .route (route),
         .fn    (fn),
         .bit_a (din_a[i]),
         .bit_b (din_b[i]),
         .bit_c (din_c[i]),
         .y     (word[i])
      );
   end

   bsa_result_reg #(.WIDTH(WIDTH)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en),
      .d       (word),
      .q       (result)
   );

   AST_ZERO_XNOR_ONES: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_sel == 2'b11 && fn_sel == 2'b10) |=> (result == ALL_ONES));   // R4

   AST_ZERO_OTHER_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_sel == 2'b11 && fn_sel != 2'b10) |=> (result == '0));         // R4

   AST_AND_BELOW_OR: assert property (@(posedge clk) disable iff (rst)
      (load_en && fn_sel == 2'b00) |=> ((result & ~($past(din_a) | $past(din_b) | $past(din_c))) == '0));  // R5

endmodule

// File: tb/bsa_alu_tb.sv
module bsa_alu_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic         load_en;
   logic [1:0]   op_sel;
   logic [1:0]   fn_sel;
   logic [W-1:0] din_a, din_b, din_c;
   logic [W-1:0] result;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] model;

   always #2 clk = ~clk;   // 250 MHz

   bsa_alu #(.WIDTH(W)) u_dut (
      .clk (clk), .rst (rst), .load_en (load_en),
      .op_sel (op_sel), .fn_sel (fn_sel),
      .din_a (din_a), .din_b (din_b), .din_c (din_c),
      .result (result)
   );

   function automatic logic [W-1:0] ref_word(logic [1:0] os, logic [1:0] fs,
                                             logic [W-1:0] a, logic [W-1:0] b,
                                             logic [W-1:0] c);
      logic [W-1:0] p, q;
      case (os)
         2'b00:   begin p = a;  q = b;  end
         2'b01:   begin p = b;  q = c;  end
         2'b10:   begin p = c;  q = a;  end
         default: begin p = '0; q = '0; end
      endcase
      case (fs)
         2'b00:   return p & q;
         2'b01:   return p | q;
         2'b10:   return ~(p ^ q);
         default: return p ^ q;
      endcase
   endfunction

   function automatic string route_tag(logic [1:0] os);
      case (os)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic string fn_tag(logic [1:0] fs);
      return (fs[1] == 1'b0) ? "R5" : "R6";
   endfunction

   task automatic check(string tag);
      checks++;
      if (result !== model) begin
         errors++;
         $display("FAIL %s: result=%h expected=%h", tag, result, model);
      end
   endtask

   // drive at falling edge, update the model at the rising edge, compare at the next falling edge
   task automatic step(logic r, logic le, logic [1:0] os, logic [1:0] fs,
                       logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                       string tag);
      rst = r; load_en = le; op_sel = os; fn_sel = fs;
      din_a = a; din_b = b; din_c = c;
      @(posedge clk);
      if (r)       model = '0;
      else if (le) model = ref_word(os, fs, a, b, c);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: result=%h expected=%h", result, model);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      model = '0;
      rst = 1'b1; load_en = 1'b0; op_sel = '0; fn_sel = '0;
      din_a = '0; din_b = '0; din_c = '0;
      @(negedge clk);
      step(1'b1, 1'b0, 2'b00, 2'b00, 8'h00, 8'h00, 8'h00, "R10 reset state");

      // every code pair, with two sets of bit-distinct data words
      for (int os = 0; os < 4; os++) begin
         for (int fs = 0; fs < 4; fs++) begin
            step(1'b0, 1'b1, os[1:0], fs[1:0], 8'hF0, 8'hCC, 8'hAA,
                 {route_tag(os[1:0]), "/", fn_tag(fs[1:0]), " R8 pattern0"});
            step(1'b0, 1'b1, os[1:0], fs[1:0], 8'h3C, 8'h96, 8'h0F,
                 {route_tag(os[1:0]), "/", fn_tag(fs[1:0]), " R8 pattern1"});
         end
      end

      // R4: forced-zero operands ignore all-ones data
      step(1'b0, 1'b1, 2'b11, 2'b10, 8'hFF, 8'hFF, 8'hFF, "R4 xnor ones");
      step(1'b0, 1'b1, 2'b11, 2'b01, 8'hFF, 8'hFF, 8'hFF, "R4 or zero");
      step(1'b0, 1'b1, 2'b11, 2'b00, 8'hFF, 8'hFF, 8'hFF, "R4 and zero");
      step(1'b0, 1'b1, 2'b11, 2'b11, 8'hFF, 8'h00, 8'hFF, "R4 xor zero");

      // R7: a single set bit affects only its own position
      for (int i = 0; i < W; i++) begin
         step(1'b0, 1'b1, 2'b00, 2'b11, 8'(1 << i), 8'h00, 8'hFF, "R7 walking one");
      end

      // R9: hold while load is off, with inputs changing
      step(1'b0, 1'b1, 2'b01, 2'b01, 8'h00, 8'h5A, 8'h81, "R8 load before hold");
      step(1'b0, 1'b0, 2'b11, 2'b10, 8'hFF, 8'h00, 8'h00, "R9 hold 1");
      step(1'b0, 1'b0, 2'b00, 2'b00, 8'h12, 8'h34, 8'h56, "R9 hold 2");

      // R10: reset wins over load
      step(1'b1, 1'b1, 2'b11, 2'b10, 8'hFF, 8'hFF, 8'hFF, "R10 reset over load");
      step(1'b0, 1'b0, 2'b11, 2'b10, 8'hFF, 8'hFF, 8'hFF, "R9 hold after reset");

      // pseudo-random sweep
      for (int n = 0; n < 200; n++) begin
         logic [1:0] os2 = 2'($urandom);
         logic [1:0] fs2 = 2'($urandom);
         step(1'b0, 1'($urandom), os2, fs2, 8'($urandom), 8'($urandom), 8'($urandom),
              {route_tag(os2), "/", fn_tag(fs2), " R8/R9 sweep"});
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule